// File: doc/BRIEF.md
# Stop-Mode Entry and Wakeup Controller

This controller decides when a small processor subsystem drops into a deep-sleep Stop state and when it comes back. A sleep request arrives with a tag: interrupt-wait entry (which also covers entry on return from a handler) or event-wait entry. When the deep-sleep flag is set, the controller gates the core clock domain and disables the PLL and both oscillators. It can also place the regulator in low-power mode. When the deep-sleep flag is clear, the request is ordinary sleep and the controller leaves everything running.

Which external lines can end Stop depends on the entry tag and on a send-event-on-pending bit. The controller captures both at entry. After a qualifying wake, the PLL and oscillators restart and the core clock stays gated for a startup delay. This delay grows when the low-power regulator was selected. When it expires, the core clock returns together with a one-cycle wake pulse. No reset is ever issued, so register and SRAM contents are untouched.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset, and in every cycle while running, `core_clk_en`, `pll_en`, `osc_int_en` and `osc_ext_en` are 1, and `reg_lowpwr` and `wake_pulse` are 0.
- R2: A `sleep_req` sampled with `deep_sleep`=1 and no qualifying pending line enters Stop. From the next cycle all four enables are 0.
- R3: A `sleep_req` sampled with `deep_sleep`=0 changes no output.
- R4: During Stop, `reg_lowpwr` equals `lp_reg_sel` as sampled at entry. It is 0 in every other state.
- R5: After interrupt-wait entry (`sleep_is_event`=0), a line wakes only when its `line_pend`, `line_irq_mode` and `line_irq_en` bits are all 1. Event-mode lines and `wake_evt` have no effect.
- R6: After event-wait entry (`sleep_is_event`=1) with send-event-on-pending captured as 0, a line wakes only when its `line_pend` and `line_evt_mode` bits are 1. Interrupt-mode lines and `wake_evt` have no effect.
- R7: After event-wait entry with send-event-on-pending captured as 1, two things wake the system. One is any line with `line_pend` and `line_irq_mode` set, whatever its `line_irq_en`. The other is `wake_evt`=1.
- R8: The entry tag and `sev_on_pend` are captured at entry. Changing them during Stop does not change which lines wake.
- R9: If a line qualifies under the requested entry context in the same cycle as `sleep_req` with `deep_sleep`=1, entry is abandoned and all enables stay 1.
- R10: A wake sampled in Stop sets `pll_en`, `osc_int_en` and `osc_ext_en` to 1 from the next cycle. `core_clk_en` stays 0 for D cycles, where D is BASE_DLY, plus LP_EXTRA when low-power was captured. In the cycle `core_clk_en` returns to 1, `wake_pulse` is 1, for that cycle only.
- R11: `sleep_req` is ignored while in Stop or during the startup delay. Wake lines are ignored during the startup delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Sleep request, sampled for one cycle |
| sleep_is_event | input | 1 | Entry tag: 1 event-wait, 0 interrupt-wait or handler return |
| deep_sleep | input | 1 | Request Stop rather than ordinary sleep |
| sev_on_pend | input | 1 | Send-event-on-pending configuration bit |
| lp_reg_sel | input | 1 | Select low-power regulator in Stop |
| line_irq_mode | input | N_LINES | Per-line interrupt-mode mask |
| line_evt_mode | input | N_LINES | Per-line event-mode mask |
| line_irq_en | input | N_LINES | Per-line interrupt-controller enable |
| line_pend | input | N_LINES | Per-line activity level |
| wake_evt | input | 1 | Internal wakeup event |
| core_clk_en | output | 1 | Core clock domain gate, 1 running |
| pll_en | output | 1 | PLL enable |
| osc_int_en | output | 1 | Internal oscillator enable |
| osc_ext_en | output | 1 | External oscillator enable |
| reg_lowpwr | output | 1 | Regulator in low-power mode |
| wake_pulse | output | 1 | One-cycle pulse when the core clock returns |

## Verification
The two functions that can fall in the same cycle are entry and wake qualification. A line may qualify in the very cycle a deep sleep request is sampled. The bench provokes this directly, with a pending enabled interrupt line held during an interrupt-wait request. It also provokes it at random, through sparse pending bits that overlap frequent requests. The bench judges it with a reference model that evaluates the requested context, not the held one: entry must be abandoned and every enable must stay high in the next cycle.

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl #(
  parameter int N_LINES  = 8,
  parameter int BASE_DLY = 4,
  parameter int LP_EXTRA = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_req,
  input  logic               sleep_is_event,
  input  logic               deep_sleep,
  input  logic               sev_on_pend,
  input  logic               lp_reg_sel,
  input  logic [N_LINES-1:0] line_irq_mode,
  input  logic [N_LINES-1:0] line_evt_mode,
  input  logic [N_LINES-1:0] line_irq_en,
  input  logic [N_LINES-1:0] line_pend,
  input  logic               wake_evt,
  output logic               core_clk_en,
  output logic               pll_en,
  output logic               osc_int_en,
  output logic               osc_ext_en,
  output logic               reg_lowpwr,
  output logic               wake_pulse
);
  localparam int MAX_DLY = BASE_DLY + LP_EXTRA;
  localparam int CW = $clog2(MAX_DLY + 1);

  typedef enum logic [1:0] {S_RUN, S_STOP, S_WAKE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          hold_evt, hold_sev, hold_lp;

  logic any_irq, any_evt, any_pend_irq;
  logic hit_now, hit_held;

  assign any_irq      = |(line_pend & line_irq_mode & line_irq_en);
  assign any_evt      = |(line_pend & line_evt_mode);
  assign any_pend_irq = |(line_pend & line_irq_mode);

  assign hit_now  = sleep_is_event ? (sev_on_pend ? (any_pend_irq | wake_evt) : any_evt) : any_irq;
  assign hit_held = hold_evt ? (hold_sev ? (any_pend_irq | wake_evt) : any_evt) : any_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_RUN;
      cnt        <= '0;
      hold_evt   <= 1'b0;
      hold_sev   <= 1'b0;
      hold_lp    <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= 1'b0;
      case (st)
        S_RUN:
          if (sleep_req && deep_sleep && !hit_now) begin
            st       <= S_STOP;
            hold_evt <= sleep_is_event;
            hold_sev <= sev_on_pend;
            hold_lp  <= lp_reg_sel;
          end
        S_STOP:
          if (hit_held) begin
            st  <= S_WAKE;
            cnt <= hold_lp ? CW'(MAX_DLY - 1) : CW'(BASE_DLY - 1);
          end
        S_WAKE:
          if (cnt == '0) begin
            st         <= S_RUN;
            wake_pulse <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        default: st <= S_RUN;
      endcase
    end
  end

  assign core_clk_en = (st == S_RUN);
  assign pll_en      = (st != S_STOP);
  assign osc_int_en  = (st != S_STOP);
  assign osc_ext_en  = (st != S_STOP);
  assign reg_lowpwr  = (st == S_STOP) && hold_lp;
endmodule

// File: rtl/stop_wake_chk.sv
module stop_wake_chk #(
  parameter int BASE_DLY = 4,
  parameter int LP_EXTRA = 6
) (
  input logic clk,
  input logic rst_n,
  input logic sleep_req,
  input logic deep_sleep,
  input logic entry_hit,
  input logic core_clk_en,
  input logic pll_en,
  input logic osc_int_en,
  input logic osc_ext_en,
  input logic reg_lowpwr,
  input logic wake_pulse
);
  logic [15:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           gap <= '0;
    else if (core_clk_en) gap <= '0;
    else if (pll_en)      gap <= gap + 16'd1;
  end

  AST_RUN_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |-> (pll_en && osc_int_en && osc_ext_en && !reg_lowpwr)); // R1
  AST_ENTRY_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en) |-> (!pll_en && !osc_int_en && !osc_ext_en)); // R2
  AST_SHALLOW_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && sleep_req && !deep_sleep) |=> core_clk_en); // R3
  AST_LOWPWR_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_lowpwr |-> (!pll_en && !core_clk_en)); // R4
  AST_ENTRY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && sleep_req && deep_sleep && entry_hit) |=> core_clk_en); // R9
  AST_PULSE_WITH_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> wake_pulse); // R10
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse); // R10
  AST_STARTUP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (32'(gap) == BASE_DLY || 32'(gap) == BASE_DLY + LP_EXTRA)); // R10
  AST_NO_SKIP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_en) |=> (!core_clk_en)); // R11
endmodule

bind stop_wake_ctrl stop_wake_chk #(.BASE_DLY(BASE_DLY), .LP_EXTRA(LP_EXTRA)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .deep_sleep(deep_sleep),
  .entry_hit(hit_now), .core_clk_en(core_clk_en), .pll_en(pll_en),
  .osc_int_en(osc_int_en), .osc_ext_en(osc_ext_en), .reg_lowpwr(reg_lowpwr),
  .wake_pulse(wake_pulse));

// File: tb/tb_stop_wake_ctrl.sv
module tb_stop_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int BASE = 4;
  localparam int EXTRA = 6;

  logic clk = 0, rst_n = 0;
  logic sleep_req = 0, sleep_is_event = 0, deep_sleep = 0, sev_on_pend = 0, lp_reg_sel = 0, wake_evt = 0;
  logic [N-1:0] line_irq_mode = '0, line_evt_mode = '0, line_irq_en = '0, line_pend = '0;
  logic core_clk_en, pll_en, osc_int_en, osc_ext_en, reg_lowpwr, wake_pulse;

  int n_chk = 0, n_bad = 0;
  bit finished = 0, cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stop_wake_ctrl #(.N_LINES(N), .BASE_DLY(BASE), .LP_EXTRA(EXTRA)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_is_event(sleep_is_event),
    .deep_sleep(deep_sleep), .sev_on_pend(sev_on_pend), .lp_reg_sel(lp_reg_sel),
    .line_irq_mode(line_irq_mode), .line_evt_mode(line_evt_mode), .line_irq_en(line_irq_en),
    .line_pend(line_pend), .wake_evt(wake_evt), .core_clk_en(core_clk_en), .pll_en(pll_en),
    .osc_int_en(osc_int_en), .osc_ext_en(osc_ext_en), .reg_lowpwr(reg_lowpwr),
    .wake_pulse(wake_pulse));

  function automatic logic qualifies(logic evt, logic sev);
    if (!evt) return |(line_pend & line_irq_mode & line_irq_en);
    if (!sev) return |(line_pend & line_evt_mode);
    return (|(line_pend & line_irq_mode)) | wake_evt;
  endfunction

  // reference model: 0 run, 1 stop, 2 startup
  int m_st = 0, m_cnt = 0;
  logic m_evt = 0, m_sev = 0, m_lp = 0, m_pulse = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_cnt <= 0; m_pulse <= 0; m_evt <= 0; m_sev <= 0; m_lp <= 0;
    end else begin
      m_pulse <= 0;
      if (m_st == 0) begin
        if (sleep_req && deep_sleep && !qualifies(sleep_is_event, sev_on_pend)) begin
          m_st <= 1; m_evt <= sleep_is_event; m_sev <= sev_on_pend; m_lp <= lp_reg_sel;
        end
      end else if (m_st == 1) begin
        if (qualifies(m_evt, m_sev)) begin
          m_st <= 2; m_cnt <= m_lp ? BASE + EXTRA : BASE;
        end
      end else begin
        if (m_cnt == 1) begin m_st <= 0; m_pulse <= 1; end
        else m_cnt <= m_cnt - 1;
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && rst_n && !finished) begin
    automatic string t = (m_st == 0) ? "R1" : (m_st == 1) ? "R2" : "R10";
    check(core_clk_en == (m_st == 0), {t, " core_clk_en"}, core_clk_en, m_st == 0);
    check(pll_en == (m_st != 1) && osc_int_en == (m_st != 1) && osc_ext_en == (m_st != 1),
          {t, " pll/osc"}, {pll_en, osc_int_en, osc_ext_en}, (m_st != 1) ? 7 : 0);
    check(reg_lowpwr == (m_st == 1 && m_lp), "R4 reg_lowpwr", reg_lowpwr, m_st == 1 && m_lp);
    check(wake_pulse == m_pulse, "R10 wake_pulse", wake_pulse, m_pulse);
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    sleep_req = 0; wake_evt = 0; line_pend = '0;
  endtask

  task automatic enter(logic evt, logic sev, logic lp);
    sleep_is_event = evt; sev_on_pend = sev; lp_reg_sel = lp; deep_sleep = 1; sleep_req = 1;
    step(); sleep_req = 0;
    check(core_clk_en == 0 && pll_en == 0, "R2 entry", core_clk_en, 0);
  endtask

  task automatic expect_wake(int d, string tag);
    int c = 0;
    step();
    check(pll_en == 1 && osc_ext_en == 1 && osc_int_en == 1, {tag, " osc restart"}, pll_en, 1);
    while (core_clk_en == 0 && c < 100) begin c++; step(); end
    check(c == d, {tag, " startup length"}, c, d);
    check(wake_pulse == 1, {tag, " pulse at return"}, wake_pulse, 1);
    quiet();
    step();
    check(wake_pulse == 0, {tag, " pulse width"}, wake_pulse, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    step(3); rst_n = 1; step();
    check(core_clk_en && pll_en && osc_int_en && osc_ext_en && !reg_lowpwr && !wake_pulse,
          "R1 reset state", {core_clk_en, pll_en, reg_lowpwr, wake_pulse}, 4'b1100);
    cmp_on = 1;

    // R3 ordinary sleep
    deep_sleep = 0; sleep_req = 1; step(); sleep_req = 0; step();
    check(core_clk_en && pll_en && osc_ext_en, "R3 shallow sleep", core_clk_en, 1);

    // R9 entry abort with a qualifying pending line
    line_irq_mode = 8'h04; line_irq_en = 8'h04; line_evt_mode = 8'h10;
    line_pend = 8'h04; deep_sleep = 1; sleep_is_event = 0; sleep_req = 1;
    step(); quiet(); step();
    check(core_clk_en && pll_en, "R9 abort", core_clk_en, 1);

    // R5 interrupt-wait qualification
    line_irq_mode = 8'h0C; line_irq_en = 8'h04;
    enter(0, 1, 0);
    line_pend = 8'h08; step(3);
    check(!core_clk_en && !pll_en, "R5 disabled irq line", pll_en, 0);
    line_pend = 8'h10; wake_evt = 1; step(3);
    check(!core_clk_en && !pll_en, "R5 event line", pll_en, 0);
    line_pend = 8'h04; wake_evt = 0;
    expect_wake(BASE, "R5");

    // R6 event-wait, no send-on-pend, low-power
    enter(1, 0, 1);
    check(reg_lowpwr == 1, "R4 low-power held", reg_lowpwr, 1);
    line_pend = 8'h04; wake_evt = 1; step(3);
    check(!pll_en, "R6 irq line / event ignored", pll_en, 0);
    line_pend = 8'h10; wake_evt = 0;
    expect_wake(BASE + EXTRA, "R6");
    check(reg_lowpwr == 0, "R4 low-power released", reg_lowpwr, 0);

    // R8 captured context
    enter(1, 0, 0);
    sleep_is_event = 0; sev_on_pend = 1; line_pend = 8'h0C; step(3);
    check(!pll_en, "R8 config change ignored", pll_en, 0);
    line_pend = 8'h10;
    expect_wake(BASE, "R8");

    // R7 event-wait with send-on-pend
    enter(1, 1, 0);
    line_pend = 8'h08;
    expect_wake(BASE, "R7 disabled irq line");
    enter(1, 1, 1);
    wake_evt = 1;
    expect_wake(BASE + EXTRA, "R7 wake event");

    // R11 requests during Stop / startup ignored
    enter(0, 0, 0);
    sleep_req = 1; lp_reg_sel = 1; step(2);
    check(reg_lowpwr == 0 && !pll_en, "R11 request in stop", reg_lowpwr, 0);
    sleep_req = 0; line_pend = 8'h04; step();
    line_pend = 8'h00; sleep_req = 1; deep_sleep = 1; step(BASE);
    check(core_clk_en && wake_pulse, "R11 request in startup", core_clk_en, 1);
    sleep_req = 0; step();
    check(core_clk_en, "R11 no re-entry", core_clk_en, 1);

    // random phase, judged by the model
    for (int i = 0; i < 4000; i++) begin
      sleep_req      = ($urandom % 6) == 0;
      sleep_is_event = $urandom;
      deep_sleep     = ($urandom % 4) != 0;
      sev_on_pend    = $urandom;
      lp_reg_sel     = $urandom;
      wake_evt       = ($urandom % 24) == 0;
      line_irq_mode  = $urandom;
      line_evt_mode  = $urandom;
      line_irq_en    = $urandom;
      for (int b = 0; b < N; b++) line_pend[b] = ($urandom % 20) == 0;
      step();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule